// File: doc/BRIEF.md
# Flash Operation Timing Sequencer

This block sequences the timed operations of an embedded flash controller. Software writes one command bit to a control register: mass erase, page erase, program, reference-cell erase or trim recall. The sequencer then raises `busy` and holds it for a cycle count built from the programmable timing registers. The analog array is stood in for by that busy interval alone. The read wait-state field is not acted on here. It is brought out on a port for the read path to use.

Every command has a main interval and a tail interval, and both are counted in clock cycles. The erase commands take the erase count and then the non-volatile hold count. Program takes the program count and then the hold count. Trim recall takes the 100 ns count and then the 10 ns count. The durations are sampled when the command starts. Timing writes made during an operation therefore only affect the next one. Status reports busy, a sticky command-error flag, and the discharge and brown-out inputs.

Register word indices: 0 control, 1 timing 0, 2 timing 1, 3 timing 2, 4 address, 5 status, 6 operation address. All registers are 32 bits wide. Reads are combinational from `rd_addr`, and writes take effect on the clock edge.

Top module: `flash_seq`

## Requirements
- R1: After reset `busy` is 0, `read_wait` is 0, and every register reads 0 except the status bits that mirror the inputs.
- R2: A control write while idle, with exactly one of bits 3 (mass erase), 4 (page erase) or 6 (reference-cell erase) set, raises `busy` from the next cycle for timing1[23:0] + timing0[31:16] cycles.
- R3: A control write while idle with only bit 5 (program) set holds `busy` for timing2[15:0] + timing0[31:16] cycles.
- R4: A control write while idle with only bit 7 (trim recall) set holds `busy` for timing2[23:16] + timing2[27:24] cycles.
- R5: When the selected sum is zero, `busy` lasts exactly one cycle.
- R6: A control write while `busy` is high is ignored. The running operation, its readback and its end cycle do not change.
- R7: A control write with more than one of bits 7:3 set does not raise `busy`. It sets status bit 1. Writing status with bit 1 set clears that flag.
- R8: A page erase copies the address register with bits 11:0 cleared (4096-byte page) into register 6. Other commands leave register 6 unchanged.
- R9: Status bit 0 equals `busy`, bit 3 equals `discharged` and bit 4 equals `brownout`.
- R10: Timing registers keep only their defined fields: timing0 bits 31:16 and 5:0, timing1 bits 23:0, timing2 bits 27:0. `read_wait` equals timing0[5:0]. Bits outside the fields read 0 and do not affect durations.
- R11: The control register reads back the command bit of the running operation while `busy` is high, and 0 when idle. A control write with none of bits 7:3 set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word index for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register word index for reads |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| brownout | input | 1 | Brown-out condition from the supply monitor |
| discharged | input | 1 | Discharge-complete indication from the array |
| busy | output | 1 | High while an operation is timing out |
| read_wait | output | 6 | Read wait states taken from timing0 |

## Verification
The assertions assume one register write per cycle. They also assume that `wr_data` is stable and known whenever `wr_en` is high, because the start and reject checks look at the command bits in that cycle. The bench changes inputs only on falling edges and holds each write for exactly one cycle. It keeps every programmed duration small enough that an operation ends well inside the run. Writes that arrive while busy go only to the control register, which is the single case the ignore rule covers.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int REG_AW = 3;
  localparam int DATA_W = 32;

  localparam logic [REG_AW-1:0] REG_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] REG_TIM0   = 3'd1;
  localparam logic [REG_AW-1:0] REG_TIM1   = 3'd2;
  localparam logic [REG_AW-1:0] REG_TIM2   = 3'd3;
  localparam logic [REG_AW-1:0] REG_ADDR   = 3'd4;
  localparam logic [REG_AW-1:0] REG_STAT   = 3'd5;
  localparam logic [REG_AW-1:0] REG_OPADDR = 3'd6;

  // command bits sit at control[OP_LO +: OP_N]
  localparam int OP_LO = 3;
  localparam int OP_N  = 5;
  typedef enum logic [2:0] {
    OP_MASS = 3'd0,
    OP_PAGE = 3'd1,
    OP_PROG = 3'd2,
    OP_REFC = 3'd3,
    OP_TRIM = 3'd4
  } op_idx_e;

  localparam int HOLD_W  = 16;
  localparam int WS_W    = 6;
  localparam int ERASE_W = 24;
  localparam int PROG_W  = 16;
  localparam int H100_W  = 8;
  localparam int T10_W   = 4;
  localparam int DUR_W   = ERASE_W + 1;
  localparam int PAGE_BITS = 12;

  typedef struct packed {
    logic [HOLD_W-1:0]  hold;
    logic [WS_W-1:0]    ws;
    logic [ERASE_W-1:0] erase;
    logic [PROG_W-1:0]  prog;
    logic [H100_W-1:0]  h100;
    logic [T10_W-1:0]   t10;
  } timing_t;
endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import flash_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output timing_t           tim,
  output logic [DATA_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim    <= '0;
      addr_q <= '0;
    end else if (we) begin
      unique case (waddr)
        REG_TIM0: begin
          tim.hold <= wdata[16 +: HOLD_W];
          tim.ws   <= wdata[0 +: WS_W];
        end
        REG_TIM1: tim.erase <= wdata[0 +: ERASE_W];
        REG_TIM2: begin
          tim.prog <= wdata[0 +: PROG_W];
          tim.h100 <= wdata[16 +: H100_W];
          tim.t10  <= wdata[24 +: T10_W];
        end
        REG_ADDR: addr_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
(
  input  logic               cmd,
  input  logic [OP_N-1:0]    ops,
  input  logic [HOLD_W-1:0]  hold,
  input  logic [ERASE_W-1:0] erase,
  input  logic [PROG_W-1:0]  prog,
  input  logic [H100_W-1:0]  h100,
  input  logic [T10_W-1:0]   t10,
  output logic               start,
  output logic               reject,
  output logic [DUR_W-1:0]   dur
);
  logic [2:0]       n_set;
  logic [DUR_W-1:0] main_c, tail_c, sum_c;

  always_comb begin
    n_set = '0;
    for (int i = 0; i < OP_N; i++) n_set = n_set + {2'b0, ops[i]};
  end

  assign start  = cmd && (n_set == 3'd1);
  assign reject = cmd && (n_set > 3'd1);

  always_comb begin
    main_c = '0;
    tail_c = '0;
    if (ops[OP_MASS] || ops[OP_PAGE] || ops[OP_REFC]) begin
      main_c = DUR_W'(erase);
      tail_c = DUR_W'(hold);
    end else if (ops[OP_PROG]) begin
      main_c = DUR_W'(prog);
      tail_c = DUR_W'(hold);
    end else if (ops[OP_TRIM]) begin
      main_c = DUR_W'(h100);
      tail_c = DUR_W'(t10);
    end
    sum_c = main_c + tail_c;
    dur   = (sum_c == '0) ? DUR_W'(1) : sum_c;
  end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              brownout,
  input  logic              discharged,
  output logic              busy,
  output logic [5:0]        read_wait
);
  timing_t           tim;
  logic [DATA_W-1:0] addr_q, op_addr_q;
  logic [OP_N-1:0]   op_q;
  logic              err_q, start, reject, last, cmd;
  logic [DUR_W-1:0]  dur;

  flash_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
    .wdata(wr_data), .tim(tim), .addr_q(addr_q)
  );

  assign cmd = wr_en && (wr_addr == REG_CTRL) && !busy;

  flash_seq_decode u_dec (
    .cmd(cmd), .ops(wr_data[OP_LO +: OP_N]),
    .hold(tim.hold), .erase(tim.erase), .prog(tim.prog),
    .h100(tim.h100), .t10(tim.t10),
    .start(start), .reject(reject), .dur(dur)
  );

  flash_seq_timer #(.W(DUR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(dur),
    .busy(busy), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q      <= '0;
      op_addr_q <= '0;
      err_q     <= 1'b0;
    end else begin
      if (start) begin
        op_q <= wr_data[OP_LO +: OP_N];
        if (wr_data[OP_LO + OP_PAGE])
          op_addr_q <= {addr_q[DATA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      end else if (last) begin
        op_q <= '0;
      end
      if (reject)
        err_q <= 1'b1;
      else if (wr_en && wr_addr == REG_STAT && wr_data[1])
        err_q <= 1'b0;
    end
  end

  assign read_wait = tim.ws;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      REG_CTRL:   rd_data[OP_LO +: OP_N] = op_q;
      REG_TIM0:   rd_data = {tim.hold, 10'b0, tim.ws};
      REG_TIM1:   rd_data = {8'b0, tim.erase};
      REG_TIM2:   rd_data = {4'b0, tim.t10, tim.h100, tim.prog};
      REG_ADDR:   rd_data = addr_q;
      REG_STAT:   rd_data = {27'b0, brownout, discharged, 1'b0, err_q, busy};
      REG_OPADDR: rd_data = op_addr_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [2:0]  rd_addr,
  input logic [31:0] rd_data,
  input logic        busy,
  input logic [4:0]  op_q
);
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 3'd0 && $countones(wr_data[7:3]) == 1) |=> busy); // R2
  AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 3'd0 && $countones(wr_data[7:3]) > 1) |=> !busy); // R7
  AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q)); // R6
  AST_OP_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_q)); // R11
  AST_IDLE_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (op_q == 5'd0)); // R11
  AST_STATUS_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd5) |-> (rd_data[0] == busy)); // R9
endmodule

bind flash_seq flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .busy(busy), .op_q(op_q)
);

// File: tb/flash_seq_test.sv
`timescale 1ns/1ps
module flash_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        brownout = 1'b0;
  logic        discharged = 1'b0;
  logic        busy;
  logic [5:0]  read_wait;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .brownout(brownout), .discharged(discharged), .busy(busy),
    .read_wait(read_wait)
  );

  // columns: control, timing0, timing1, timing2
  localparam logic [31:0] VEC [7][4] = '{
    '{32'h08, 32'h0005_0003, 32'd20,        32'h0},           // R2 mass erase
    '{32'h10, 32'h0002_0000, 32'd7,         32'h0},           // R2 page erase
    '{32'h20, 32'h0004_0000, 32'd100,       32'h0000_000B},   // R3 program
    '{32'h40, 32'h0,         32'd3,         32'h0},           // R2 ref erase
    '{32'h80, 32'h0009_0000, 32'd50,        32'h060A_0050},   // R4 recall
    '{32'h20, 32'h0,         32'h0,         32'h0},           // R5 zero
    '{32'h08, 32'h0001_0000, 32'hFF00_0010, 32'h0}            // R10 masking
  };
  localparam int EXP [7] = '{25, 9, 15, 3, 16, 1, 17};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'h0);
    check("R1 read_wait", {26'b0, read_wait}, 32'h0);
    for (int a = 0; a < 7; a++) begin
      rd_addr = 3'(a); #0.1;
      check("R1 register", rd_data, 32'h0);
    end

    // table walk
    for (int i = 0; i < 7; i++) begin
      wr(3'd1, VEC[i][1]);
      wr(3'd2, VEC[i][2]);
      wr(3'd3, VEC[i][3]);
      rd_addr = 3'd0;
      wr(3'd0, VEC[i][0]);
      check("R11 control readback", rd_data, VEC[i][0]);
      measure(n);
      check("R2/R3/R4/R5 busy length", 32'(n), 32'(EXP[i]));
      check("R11 idle control", rd_data, 32'h0);
    end

    // R10 field masking and wait states
    wr(3'd1, 32'hFFFF_FFFF);
    rd_addr = 3'd1; #0.1;
    check("R10 timing0 mask", rd_data, 32'hFFFF_003F);
    check("R10 read_wait", {26'b0, read_wait}, 32'h3F);
    wr(3'd3, 32'hFFFF_FFFF);
    rd_addr = 3'd3; #0.1;
    check("R10 timing2 mask", rd_data, 32'h0FFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    rd_addr = 3'd2; #0.1;
    check("R10 timing1 mask", rd_data, 32'h00FF_FFFF);

    // R7 reject and clear
    wr(3'd1, 32'h0005_0000);
    wr(3'd2, 32'd15);
    rd_addr = 3'd5;
    wr(3'd0, 32'h18);
    check("R7 no busy", {31'b0, busy}, 32'h0);
    check("R7 error flag", rd_data, 32'h2);
    wr(3'd5, 32'h2);
    check("R7 error cleared", rd_data, 32'h0);

    // R11 no-op command
    wr(3'd0, 32'h07);
    check("R11 no-op busy", {31'b0, busy}, 32'h0);
    check("R11 no-op status", rd_data, 32'h0);

    // R6 ignore while busy: erase 15 + hold 5
    rd_addr = 3'd0;
    wr(3'd0, 32'h08);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 3) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h20; end
      else wr_en = 1'b0;
      @(negedge clk);
      if (n == 3) check("R6 running op kept", rd_data, 32'h08);
    end
    wr_en = 1'b0;
    check("R6 end cycle kept", 32'(n), 32'd20);

    // R8 page address capture
    wr(3'd4, 32'h0001_2345);
    wr(3'd2, 32'd2);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h10);
    measure(n);
    rd_addr = 3'd6; #0.1;
    check("R8 page address", rd_data, 32'h0001_2000);
    wr(3'd4, 32'h0000_7777);
    wr(3'd0, 32'h08);
    measure(n);
    check("R8 unchanged by other op", rd_data, 32'h0001_2000);

    // R9 status inputs
    rd_addr = 3'd5;
    brownout = 1'b1; discharged = 1'b0; #0.1;
    check("R9 brownout", rd_data, 32'h10);
    brownout = 1'b0; discharged = 1'b1; #0.1;
    check("R9 discharged", rd_data, 32'h08);
    discharged = 1'b0;
    wr(3'd0, 32'h08);
    check("R9 busy bit", rd_data, 32'h01);
    measure(n);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule